// File: doc/BRIEF.md
# Shared Address/Data Bus Ownership Controller

This block sits on the external-agent side of a processor system bus on which addresses and data share one 64-bit path, with a 12-bit command path beside it. It decides which side drives those paths. After reset the agent owns them. The processor asks for them with a request line. The agent answers with a grant, after one idle cycle in which nobody drives. The grant then holds until the processor signals release. After another idle cycle, ownership returns to the agent.

The bidirectional paths are modelled as separate in, out and output-enable ports. While the agent owns the bus, the agent's own logic sends address or data cycles through a valid/ready pair. While the processor owns it, every cycle marked valid is captured. The most significant command bit marks an address cycle. Address cycles are screened against two flow-control lines driven back to the processor: one for the read class and one for the write class. A request of a class whose line was low is refused and flagged. Completion responses from the agent and coherent-state codes from the processor are registered through.

Top module: `sysbus_arbiter`

## Requirements
- R1: While rst_n is low and just after it: grant_o=0, bus_oe_o=1, agent_rel_o=0, tx_ready_o=1, val_o=0, cap_v_o=0, err_o=0, rd_rdy_o=0, wr_rdy_o=0.
- R2: With the agent owning the bus, proc_req_i high and tx_valid_i low at an edge gives one cycle with grant_o=0, bus_oe_o=0 and agent_rel_o=1. In the cycle after that, grant_o=1 with bus_oe_o=0.
- R3: Once high, grant_o stays high until proc_rel_i is sampled high. The next cycle has grant_o=0 and bus_oe_o=0. In the cycle after that, bus_oe_o=1 and tx_ready_o=1.
- R4: bus_oe_o and grant_o are never high in the same cycle. tx_ready_o is high exactly when bus_oe_o is high.
- R5: When tx_valid_i and tx_ready_o are both high at an edge, the next cycle has val_o=1, with ad_o and cmd_o equal to the sent values. Otherwise val_o is 0 and ad_o and cmd_o hold. A pending send takes priority over proc_req_i.
- R6: While grant_o is high, val_i high at an edge with an accepted cycle gives cap_v_o=1 in the next cycle. In that cycle, cap_addr_o equals cmd_i[11], and cap_ad_o and cap_cmd_o equal the sampled ad_i and cmd_i.
- R7: The request kind is cmd_i[10:8]: 0 is read, 1 is upgrade, 2 is write, 3 is eliminate. An address cycle of kind 0 or 1 while rd_rdy_o is low, or of kind 2 or 3 while wr_rdy_o is low, is refused. For a refused cycle, the next cycle has err_o=1 and cap_v_o=0, and the captured values hold. Other kinds, and data cycles, are never refused.
- R8: rd_rdy_o and wr_rdy_o equal rd_ok_i and wr_ok_i as sampled at the previous edge.
- R9: val_i is ignored, and so is proc_rel_i, unless grant_o is high. Such a cycle gives no cap_v_o, no err_o and no change of ownership.
- R10: resp_o and coh_o equal resp_i and coh_i as sampled at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| proc_req_i | input | 1 | Processor asks for bus ownership |
| proc_rel_i | input | 1 | Processor gives up ownership |
| grant_o | output | 1 | Processor owns the bus |
| agent_rel_o | output | 1 | Agent gives up ownership (turnaround cycle) |
| rd_ok_i | input | 1 | Agent can take read-class requests |
| wr_ok_i | input | 1 | Agent can take write-class requests |
| rd_rdy_o | output | 1 | Read/upgrade ready to processor |
| wr_rdy_o | output | 1 | Write/eliminate ready to processor |
| ad_i | input | 64 | Address/data bus as seen from the bus |
| ad_o | output | 64 | Address/data value the agent drives |
| cmd_i | input | 12 | Command bus as seen from the bus |
| cmd_o | output | 12 | Command value the agent drives |
| bus_oe_o | output | 1 | Agent output enable for ad and cmd |
| val_i | input | 1 | Processor valid strobe |
| val_o | output | 1 | Agent valid strobe |
| tx_valid_i | input | 1 | Agent logic has a cycle to send |
| tx_ad_i | input | 64 | Address/data to send |
| tx_cmd_i | input | 12 | Command to send |
| tx_ready_o | output | 1 | Send accepted this cycle |
| cap_v_o | output | 1 | Captured processor cycle valid |
| cap_addr_o | output | 1 | Captured cycle is an address cycle |
| cap_ad_o | output | 64 | Captured address/data |
| cap_cmd_o | output | 12 | Captured command |
| err_o | output | 1 | Refused processor request |
| resp_i | input | 5 | Completion response from agent logic |
| resp_o | output | 5 | Completion response to processor |
| coh_i | input | 3 | Coherent state code from processor |
| coh_o | output | 3 | Registered coherent state code |

## Verification
The bench goes after the two handovers. A design that skips the idle cycle would drive the bus in the same cycle as the processor, or one cycle too early. The bench also sends a cycle and raises a request in the same cycle. A design without send priority would drop the send or switch owner with a strobe still pending. Each request kind is issued with its ready line low and with it high. Strobes and releases are also raised while the agent owns the bus. A design that used the wrong ready line, or listened outside ownership, would flag or capture the wrong cycles.

// File: rtl/sysbus_arbiter.sv
module sysbus_arbiter #(
  parameter int AD_W   = 64,
  parameter int CMD_W  = 12,
  parameter int RESP_W = 5,
  parameter int COH_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              proc_req_i,
  input  logic              proc_rel_i,
  output logic              grant_o,
  output logic              agent_rel_o,
  input  logic              rd_ok_i,
  input  logic              wr_ok_i,
  output logic              rd_rdy_o,
  output logic              wr_rdy_o,
  input  logic [AD_W-1:0]   ad_i,
  output logic [AD_W-1:0]   ad_o,
  input  logic [CMD_W-1:0]  cmd_i,
  output logic [CMD_W-1:0]  cmd_o,
  output logic              bus_oe_o,
  input  logic              val_i,
  output logic              val_o,
  input  logic              tx_valid_i,
  input  logic [AD_W-1:0]   tx_ad_i,
  input  logic [CMD_W-1:0]  tx_cmd_i,
  output logic              tx_ready_o,
  output logic              cap_v_o,
  output logic              cap_addr_o,
  output logic [AD_W-1:0]   cap_ad_o,
  output logic [CMD_W-1:0]  cap_cmd_o,
  output logic              err_o,
  input  logic [RESP_W-1:0] resp_i,
  output logic [RESP_W-1:0] resp_o,
  input  logic [COH_W-1:0]  coh_i,
  output logic [COH_W-1:0]  coh_o
);
  localparam int KIND_HI = CMD_W - 2;

  typedef enum logic [1:0] {AGENT, TO_PROC, PROC, TO_AGENT} own_t;
  own_t st, st_nx;

  logic       is_addr, rd_class, wr_class, refuse, take;
  logic [2:0] kind;

  assign grant_o     = (st == PROC);
  assign bus_oe_o    = (st == AGENT);
  assign tx_ready_o  = (st == AGENT);
  assign agent_rel_o = (st == TO_PROC);

  assign is_addr  = cmd_i[CMD_W-1];
  assign kind     = cmd_i[KIND_HI -: 3];
  assign rd_class = (kind == 3'd0) || (kind == 3'd1);
  assign wr_class = (kind == 3'd2) || (kind == 3'd3);
  assign take     = grant_o && val_i;
  assign refuse   = take && is_addr && ((rd_class && !rd_rdy_o) || (wr_class && !wr_rdy_o));

  always_comb begin
    st_nx = st;
    case (st)
      AGENT:    if (!tx_valid_i && proc_req_i) st_nx = TO_PROC;
      TO_PROC:  st_nx = PROC;
      PROC:     if (proc_rel_i) st_nx = TO_AGENT;
      default:  st_nx = AGENT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= AGENT;
      val_o      <= 1'b0;
      ad_o       <= '0;
      cmd_o      <= '0;
      rd_rdy_o   <= 1'b0;
      wr_rdy_o   <= 1'b0;
      cap_v_o    <= 1'b0;
      cap_addr_o <= 1'b0;
      cap_ad_o   <= '0;
      cap_cmd_o  <= '0;
      err_o      <= 1'b0;
      resp_o     <= '0;
      coh_o      <= '0;
    end else begin
      st       <= st_nx;
      rd_rdy_o <= rd_ok_i;
      wr_rdy_o <= wr_ok_i;
      resp_o   <= resp_i;
      coh_o    <= coh_i;
      val_o    <= tx_valid_i && tx_ready_o;
      if (tx_valid_i && tx_ready_o) begin
        ad_o  <= tx_ad_i;
        cmd_o <= tx_cmd_i;
      end
      cap_v_o <= take && !refuse;
      err_o   <= refuse;
      if (take && !refuse) begin
        cap_addr_o <= is_addr;
        cap_ad_o   <= ad_i;
        cap_cmd_o  <= cmd_i;
      end
    end
  end

  AST_NO_DUAL_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_oe_o && grant_o)); // R4
  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o && !proc_rel_i |=> grant_o); // R3
  AST_OE_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe_o) |-> $past(!grant_o)); // R3
  AST_GRANT_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_o) |-> $past(!bus_oe_o)); // R2
  AST_VAL_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    val_o |-> bus_oe_o); // R5
  AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_o && cap_v_o)); // R7
  AST_CAP_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_v_o || err_o) |-> $past(grant_o)); // R9
endmodule

// File: tb/sysbus_arbiter_bench.sv
module sysbus_arbiter_bench;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic proc_req_i = 0, proc_rel_i = 0, rd_ok_i = 0, wr_ok_i = 0, val_i = 0, tx_valid_i = 0;
  logic [63:0] ad_i = 0, tx_ad_i = 0;
  logic [11:0] cmd_i = 0, tx_cmd_i = 0;
  logic [4:0] resp_i = 0;
  logic [2:0] coh_i = 0;
  logic grant_o, agent_rel_o, rd_rdy_o, wr_rdy_o, bus_oe_o, val_o, tx_ready_o;
  logic cap_v_o, cap_addr_o, err_o;
  logic [63:0] ad_o, cap_ad_o;
  logic [11:0] cmd_o, cap_cmd_o;
  logic [4:0] resp_o;
  logic [2:0] coh_o;

  sysbus_arbiter u_sysbus_arbiter (.*);

  int total = 0, bad = 0;
  int m_st = 0;
  logic m_val = 0, m_cv = 0, m_ca = 0, m_err = 0, m_rr = 0, m_wr = 0;
  logic [63:0] m_ad = 0, m_cad = 0;
  logic [11:0] m_cmd = 0, m_ccmd = 0;
  logic [4:0] m_resp = 0;
  logic [2:0] m_coh = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit refused(input logic [11:0] c, input logic rr, input logic wr);
    logic [2:0] k = c[10:8];
    return c[11] && ((k <= 3'd1 && !rr) || ((k == 3'd2 || k == 3'd3) && !wr));
  endfunction

  task automatic model;
    logic acc;
    int nx;
    acc = (m_st == 2) && val_i && !refused(cmd_i, m_rr, m_wr);
    m_err = (m_st == 2) && val_i && refused(cmd_i, m_rr, m_wr);
    m_cv = acc;
    if (acc) begin m_ca = cmd_i[11]; m_cad = ad_i; m_ccmd = cmd_i; end
    m_val = (m_st == 0) && tx_valid_i;
    if (m_val) begin m_ad = tx_ad_i; m_cmd = tx_cmd_i; end
    nx = m_st;
    case (m_st)
      0: if (!tx_valid_i && proc_req_i) nx = 1;
      1: nx = 2;
      2: if (proc_rel_i) nx = 3;
      default: nx = 0;
    endcase
    m_st = nx;
    m_rr = rd_ok_i; m_wr = wr_ok_i; m_resp = resp_i; m_coh = coh_i;
  endtask

  task automatic compare;
    chk(grant_o == (m_st == 2) && bus_oe_o == (m_st == 0) && agent_rel_o == (m_st == 1),
        "R2/R3 ownership", {grant_o, bus_oe_o, agent_rel_o}, {m_st == 2, m_st == 0, m_st == 1});
    chk(!(grant_o && bus_oe_o) && tx_ready_o == bus_oe_o, "R4 single driver",
        {grant_o, bus_oe_o, tx_ready_o}, {m_st == 2, m_st == 0, m_st == 0});
    chk(val_o == m_val && ad_o == m_ad && cmd_o == m_cmd, "R5 agent send", {val_o, cmd_o, ad_o[31:0]},
        {m_val, m_cmd, m_ad[31:0]});
    chk(cap_v_o == m_cv && cap_addr_o == m_ca && cap_ad_o == m_cad && cap_cmd_o == m_ccmd, "R6 capture",
        {cap_v_o, cap_addr_o, cap_cmd_o, cap_ad_o[31:0]}, {m_cv, m_ca, m_ccmd, m_cad[31:0]});
    chk(err_o == m_err, "R7 refuse", err_o, m_err);
    chk(rd_rdy_o == m_rr && wr_rdy_o == m_wr, "R8 ready", {rd_rdy_o, wr_rdy_o}, {m_rr, m_wr});
    chk(resp_o == m_resp && coh_o == m_coh, "R10 passthrough", {resp_o, coh_o}, {m_resp, m_coh});
  endtask

  task automatic cyc;
    model();
    @(posedge clk); #1;
    compare();
  endtask

  task automatic rand_in;
    proc_req_i = ($urandom % 4) == 0;
    proc_rel_i = ($urandom % 5) == 0;
    tx_valid_i = ($urandom % 5) < 2;
    tx_ad_i = {$urandom, $urandom};
    tx_cmd_i = 12'($urandom);
    val_i = $urandom % 2;
    ad_i = {$urandom, $urandom};
    cmd_i = 12'($urandom);
    rd_ok_i = ($urandom % 10) < 6;
    wr_ok_i = ($urandom % 10) < 6;
    resp_i = 5'($urandom);
    coh_i = 3'($urandom);
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", total, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset values
    chk(!grant_o && bus_oe_o && !agent_rel_o && tx_ready_o && !val_o && !cap_v_o && !err_o && !rd_rdy_o && !wr_rdy_o,
        "R1 reset", {grant_o, bus_oe_o, agent_rel_o, tx_ready_o, val_o, cap_v_o, err_o}, 7'b0101000);
    rst_n = 1;
    @(posedge clk); #1;
    compare();

    // R5 send priority over request
    tx_valid_i = 1; proc_req_i = 1; tx_ad_i = 64'h1122_3344_5566_7788; tx_cmd_i = 12'h8A5;
    cyc();
    chk(val_o && bus_oe_o && !agent_rel_o, "R5 priority", {val_o, bus_oe_o, agent_rel_o}, 3'b110);

    // R9 strobe and release ignored while agent owns
    tx_valid_i = 1; proc_req_i = 0; val_i = 1; proc_rel_i = 1; cmd_i = 12'h800;
    cyc();
    chk(!cap_v_o && !err_o && bus_oe_o, "R9 ignored", {cap_v_o, err_o, bus_oe_o}, 3'b001);

    // R2 handover with idle cycle
    tx_valid_i = 0; val_i = 0; proc_rel_i = 0; proc_req_i = 1; rd_ok_i = 0; wr_ok_i = 1;
    cyc();
    chk(!grant_o && !bus_oe_o && agent_rel_o, "R2 idle", {grant_o, bus_oe_o, agent_rel_o}, 3'b001);
    proc_req_i = 0;
    cyc();
    chk(grant_o && !bus_oe_o, "R2 grant", {grant_o, bus_oe_o}, 2'b10);

    // R7 read kind refused with rd_rdy low, write kind taken
    val_i = 1; cmd_i = 12'h800; ad_i = 64'hAAAA;
    cyc();
    chk(err_o && !cap_v_o, "R7 read refused", {err_o, cap_v_o}, 2'b10);
    cmd_i = 12'hA00; ad_i = 64'hBBBB;
    cyc();
    chk(cap_v_o && !err_o && cap_ad_o == 64'hBBBB, "R7 write taken", cap_ad_o, 64'hBBBB);
    cmd_i = 12'hD00; wr_ok_i = 0;
    cyc();
    cmd_i = 12'h300; // data cycle never refused
    cyc();
    chk(cap_v_o && !cap_addr_o, "R6 data cycle", {cap_v_o, cap_addr_o}, 2'b10);
    cmd_i = 12'hB00; // eliminate with wr_rdy low
    cyc();
    chk(err_o, "R7 eliminate refused", err_o, 1);

    // R3 grant holds, then release with idle cycle
    val_i = 0;
    repeat (3) cyc();
    chk(grant_o, "R3 hold", grant_o, 1);
    proc_rel_i = 1;
    cyc();
    chk(!grant_o && !bus_oe_o, "R3 idle", {grant_o, bus_oe_o}, 2'b00);
    proc_rel_i = 0;
    cyc();
    chk(bus_oe_o && tx_ready_o, "R3 back", {bus_oe_o, tx_ready_o}, 2'b11);

    for (int i = 0; i < 3000; i++) begin
      rand_in();
      cyc();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule